// File: doc/BRIEF.md
# SRAM Pattern Self-Test Engine

This block is a built-in test sequencer for a small single-port synchronous memory. A one-cycle start pulse launches a run that walks the whole address space several times. Each pass first fills every location with a known pattern and then reads every location back, comparing the returned word against the value that should be there. Any data a system had stored in the memory is destroyed by a run.

Four passes use the same word at every address (all ones, two alternating-bit words, all zeros). These catch stuck and shorted data bits. A final pass stores each location's own low address bits, so every cell holds distinct data. This catches address bits that are stuck or tied together, which a constant-data pass cannot see. The first wrong read ends the run at once and records the failing address. A clean run ends with a pass indication. The result stays visible until the next start or a reset.

The memory port is modelled as synchronous: a word addressed in one cycle appears on the read-data input during the next cycle, and a write takes effect at the clock edge that ends the cycle in which write-enable is high.

Top module: `sram_pattern_bist`

## Requirements
- R1: Synchronous active-high reset, including a reset in the middle of a run, clears test_done, test_pass, test_fail, mem_we, mem_addr, mem_wdata and fail_addr to zero on the next clock edge.
- R2: A start pulse sampled while idle begins a run. In the following cycle mem_we=1, mem_addr=0 and mem_wdata=4'b1111, and test_done, test_pass, test_fail and fail_addr read 0.
- R3: A run has five passes in this fixed order of write data: 4'b1111, 4'b1010, 4'b0101, 4'b0000, then data equal to the address (addr[3:0]). Each pass spends one cycle per address writing addresses 0 to 15 in ascending order, then one cycle per address reading addresses 0 to 15 in ascending order (mem_we=0). That makes 32 cycles per pass, and the next pass starts immediately.
- R4: The read data for the address issued in cycle t is taken from mem_rdata in cycle t+1. The comparison result appears on the outputs in cycle t+2.
- R5: A run with no mismatch raises test_done and test_pass together 161 clock edges after the edge that sampled start. test_fail stays 0.
- R6: At the first mismatch, from the next cycle on: test_done=1, test_fail=1, test_pass=0, mem_we=0, mem_addr=0, and fail_addr holds the address whose read mismatched. No further memory accesses are made.
- R7: test_done, test_pass, test_fail and fail_addr stay unchanged after a run ends, until the next start pulse or reset.
- R8: A start pulse while a run is in progress has no effect. The run completes on its original schedule.
- R9: test_pass and test_fail are never 1 together, and either of them being 1 implies test_done=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a run when idle |
| mem_addr | output | ADDR_W | Memory address, registered |
| mem_we | output | 1 | Memory write enable, registered |
| mem_wdata | output | DATA_W | Memory write data, registered |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the address |
| test_done | output | 1 | Run finished (latched) |
| test_pass | output | 1 | Run finished with no mismatch (latched) |
| test_fail | output | 1 | Run stopped on a mismatch (latched) |
| fail_addr | output | ADDR_W | Address of the first mismatching read |

## Verification
The hardest situation to reach from the ports is an address-line fault. Every constant-data pass reads back correctly under such a fault, so only the last pass exposes it. The bench's memory model can tie the top address bit low, so that the upper half of the array aliases the lower half. The run must then survive four passes and stop in the address pass at address 0 on exactly the predicted cycle. Single-cell and stuck-data-bit faults are also injected, as are restart attempts and a reset during a run. A behavioural per-cycle model checks every output on every clock.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [2:0] {
    PAT_ONES   = 3'd0,
    PAT_HI_ALT = 3'd1,
    PAT_LO_ALT = 3'd2,
    PAT_ZEROS  = 3'd3,
    PAT_ADDR   = 3'd4
  } pat_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WRITE  = 2'd1,
    ST_READ   = 2'd2,
    ST_FINISH = 2'd3
  } seq_state_e;

  localparam pat_e LAST_PAT = PAT_ADDR;

endpackage

// File: rtl/sst_pattern_gen.sv
module sst_pattern_gen
  import sst_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  pat_e              pat,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic ODD = ((i % 2) == 1);
    logic a_bit;
    logic d_bit;

    if (i < ADDR_W) begin : g_from_addr
      assign a_bit = addr[i];
    end else begin : g_pad
      assign a_bit = 1'b0;
    end

    always_comb begin
      case (pat)
        PAT_ONES:   d_bit = 1'b1;
        PAT_HI_ALT: d_bit = ODD;
        PAT_LO_ALT: d_bit = ~ODD;
        PAT_ZEROS:  d_bit = 1'b0;
        default:    d_bit = a_bit;
      endcase
    end

    assign data[i] = d_bit;
  end

endmodule

// File: rtl/sst_read_checker.sv
module sst_read_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issue,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_exp,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mismatch,
  output logic [ADDR_W-1:0] mis_addr
);

  logic              chk_vld_q;
  logic [ADDR_W-1:0] chk_addr_q;
  logic [DATA_W-1:0] chk_exp_q;

  assign mismatch = chk_vld_q && (mem_rdata != chk_exp_q);
  assign mis_addr = chk_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_vld_q  <= 1'b0;
      chk_addr_q <= '0;
      chk_exp_q  <= '0;
    end else begin
      chk_vld_q  <= rd_issue && !mismatch;
      chk_addr_q <= rd_addr;
      chk_exp_q  <= rd_exp;
    end
  end

  // R4
  cmp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_issue && !mismatch) |=> (chk_vld_q && chk_addr_q == $past(rd_addr)));

endmodule

// File: rtl/sst_sequencer.sv
module sst_sequencer
  import sst_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mismatch,
  input  logic [ADDR_W-1:0] mis_addr,
  input  logic [DATA_W-1:0] nxt_data,
  output pat_e              cur_pat,
  output logic [ADDR_W-1:0] cur_addr,
  output pat_e              nxt_pat,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              rd_issue,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              test_done,
  output logic              test_pass,
  output logic              test_fail,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [ADDR_W-1:0] ONE_ADDR = {{(ADDR_W-1){1'b0}}, 1'b1};

  seq_state_e        st_q;
  pat_e              pat_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q, pass_q, fail_q;
  logic [ADDR_W-1:0] faddr_q;

  logic at_top;
  assign at_top = (addr_q == TOP_ADDR);

  always_comb begin
    nxt_pat  = pat_q;
    nxt_addr = addr_q + ONE_ADDR;
    if (st_q == ST_IDLE) begin
      nxt_pat  = PAT_ONES;
      nxt_addr = '0;
    end else if (st_q == ST_READ && at_top) begin
      nxt_pat  = pat_e'(pat_q + 3'd1);
      nxt_addr = '0;
    end
  end

  assign cur_pat  = pat_q;
  assign cur_addr = addr_q;
  assign rd_issue = (st_q == ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pat_q   <= PAT_ONES;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
    end else if (mismatch) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b1;
      pass_q  <= 1'b0;
      fail_q  <= 1'b1;
      faddr_q <= mis_addr;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q    <= ST_WRITE;
            pat_q   <= nxt_pat;
            addr_q  <= nxt_addr;
            we_q    <= 1'b1;
            wdata_q <= nxt_data;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
            faddr_q <= '0;
          end
        end
        ST_WRITE: begin
          if (at_top) begin
            st_q   <= ST_READ;
            addr_q <= '0;
            we_q   <= 1'b0;
          end else begin
            addr_q  <= nxt_addr;
            wdata_q <= nxt_data;
          end
        end
        ST_READ: begin
          if (at_top) begin
            if (pat_q == LAST_PAT) begin
              st_q <= ST_FINISH;
            end else begin
              st_q    <= ST_WRITE;
              pat_q   <= nxt_pat;
              addr_q  <= nxt_addr;
              we_q    <= 1'b1;
              wdata_q <= nxt_data;
            end
          end else begin
            addr_q <= nxt_addr;
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          pass_q <= 1'b1;
        end
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
  assign test_done = done_q;
  assign test_pass = pass_q;
  assign test_fail = fail_q;
  assign fail_addr = faddr_q;

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (rst) !(pass_q && fail_q));
  // R9
  verdict_done_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_q || fail_q) |-> done_q);
  // R6
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> (done_q && fail_q && !we_q && faddr_q == $past(mis_addr)));
  // R6
  quiet_after_fail_chk: assert property (@(posedge clk) disable iff (rst)
    fail_q |-> !we_q);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> (done_q && $stable(pass_q) && $stable(fail_q) && $stable(faddr_q)));
  // R3
  wr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (we_q && $past(we_q)) |-> (addr_q == $past(addr_q) + ONE_ADDR));

endmodule

// File: rtl/sram_pattern_bist.sv
module sram_pattern_bist
  import sst_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              test_done,
  output logic              test_pass,
  output logic              test_fail,
  output logic [ADDR_W-1:0] fail_addr
);

  pat_e              cur_pat, nxt_pat;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, mis_addr;
  logic [DATA_W-1:0] cur_data, nxt_data;
  logic              rd_issue, mismatch;

  sst_pattern_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat_next (
    .pat  (nxt_pat),
    .addr (nxt_addr),
    .data (nxt_data)
  );

  sst_pattern_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat_cur (
    .pat  (cur_pat),
    .addr (cur_addr),
    .data (cur_data)
  );

  sst_read_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_check (
    .clk       (clk),
    .rst       (rst),
    .rd_issue  (rd_issue),
    .rd_addr   (cur_addr),
    .rd_exp    (cur_data),
    .mem_rdata (mem_rdata),
    .mismatch  (mismatch),
    .mis_addr  (mis_addr)
  );

  sst_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mismatch  (mismatch),
    .mis_addr  (mis_addr),
    .nxt_data  (nxt_data),
    .cur_pat   (cur_pat),
    .cur_addr  (cur_addr),
    .nxt_pat   (nxt_pat),
    .nxt_addr  (nxt_addr),
    .rd_issue  (rd_issue),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .test_done (test_done),
    .test_pass (test_pass),
    .test_fail (test_fail),
    .fail_addr (fail_addr)
  );

endmodule

// File: tb/sram_pattern_bist_test.sv
`timescale 1ns/1ps
module sram_pattern_bist_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] mem_addr, mem_wdata, fail_addr;
  logic [3:0] mem_rdata = 4'h0;
  logic       mem_we, test_done, test_pass, test_fail;

  int n_checks = 0;
  int n_fail   = 0;
  int wd       = 0;
  bit finished = 0;
  int fault    = 0;  // 0 none, 1 data bit2 stuck low, 2 addr bit3 stuck low, 3 cell 5 bit0 stuck high

  always #10 clk = ~clk;

  sram_pattern_bist uut (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .test_done(test_done), .test_pass(test_pass), .test_fail(test_fail), .fail_addr(fail_addr)
  );

  // memory with injectable faults, read-first synchronous port
  logic [3:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = 4'h0;

  always @(posedge clk) begin
    logic [3:0] a;
    logic [3:0] d;
    a = (fault == 2) ? (mem_addr & 4'h7) : mem_addr;
    d = mem[a];
    if (fault == 1) d = d & 4'b1011;
    if (fault == 3 && a == 4'd5) d = d | 4'b0001;
    mem_rdata <= d;
    if (mem_we) mem[a] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  function automatic logic [3:0] exp_pat(input int p, input int a);
    case (p)
      0: return 4'b1111;
      1: return 4'b1010;
      2: return 4'b0101;
      3: return 4'b0000;
      default: return 4'(a);
    endcase
  endfunction

  // behavioural per-cycle reference model
  bit         m_busy = 0, m_we = 0, m_rd = 0, m_done = 0, m_pass = 0, m_fail = 0;
  int         m_t = 0;
  logic [3:0] m_addr = 0, m_wdata = 0, m_faddr = 0, m_rexp = 0;
  bit         due_vld = 0;
  logic [3:0] due_addr = 0, due_exp = 0;

  task automatic sched(input int t);
    int p, off;
    p = t / 32;
    off = t % 32;
    m_we = (off < 16);
    m_rd = !m_we;
    m_addr = 4'(off % 16);
    if (m_we) m_wdata = exp_pat(p, off % 16);
    m_rexp = exp_pat(p, off % 16);
  endtask

  always @(negedge clk) begin
    logic [19:0] act, exp;
    bit mism, c_rd;
    logic [3:0] c_addr, c_exp;
    act = {mem_we, mem_addr, mem_we ? mem_wdata : 4'h0, test_done, test_pass, test_fail, fail_addr, 1'b0};
    exp = {m_we, m_addr, m_we ? m_wdata : 4'h0, m_done, m_pass, m_fail, m_faddr, 1'b0};
    if (!finished) chk(act === exp, "R3/R4/R6 per-cycle model", 32'(act), 32'(exp));
    c_rd = m_rd; c_addr = m_addr; c_exp = m_rexp;
    if (rst) begin
      m_busy = 0; m_we = 0; m_rd = 0; m_done = 0; m_pass = 0; m_fail = 0;
      m_addr = 0; m_wdata = 0; m_faddr = 0; due_vld = 0;
    end else begin
      mism = due_vld && (mem_rdata !== due_exp);
      if (mism) begin
        m_busy = 0; m_we = 0; m_rd = 0; m_addr = 0;
        m_done = 1; m_fail = 1; m_pass = 0; m_faddr = due_addr;
      end else if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_t = 0; sched(0);
          m_done = 0; m_pass = 0; m_fail = 0; m_faddr = 0;
        end
      end else begin
        m_t++;
        if (m_t < 160) sched(m_t);
        else if (m_t == 160) begin m_we = 0; m_rd = 0; end
        else begin m_busy = 0; m_done = 1; m_pass = 1; end
      end
      due_vld = c_rd && !mism;
      due_addr = c_addr;
      due_exp = c_exp;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 100000 && !finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL R5 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  task automatic pulse_start();
    @(posedge clk); start <= 1'b1;
    @(posedge clk); start <= 1'b0;
  endtask

  task automatic wait_done(inout int n);
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!test_done && n < 400);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({test_done, test_pass, test_fail, mem_we} == 4'b0000, "R1 flags after reset",
        {test_done, test_pass, test_fail, mem_we}, 0);
    chk(mem_addr == 0 && fail_addr == 0, "R1 addr after reset", {mem_addr, fail_addr}, 0);

    // R2 + R5 clean run
    fault = 0;
    pulse_start();
    @(negedge clk);
    chk(mem_we && mem_addr == 0 && mem_wdata == 4'b1111, "R2 first write", {mem_we, mem_addr, mem_wdata}, {1'b1, 4'h0, 4'hF});
    chk(!test_done && !test_fail && !test_pass, "R2 flags cleared", {test_done, test_pass, test_fail}, 0);
    n = 0;
    wait_done(n);
    chk(n == 161, "R5 clean run length", n, 161);
    chk(test_pass && !test_fail, "R5 pass verdict", {test_pass, test_fail}, 2'b10);
    chk(!(test_pass && test_fail), "R9 exclusive verdict", {test_pass, test_fail}, 2'b10);

    // R7 hold
    repeat (10) @(negedge clk);
    chk(test_done && test_pass && !test_fail, "R7 result held", {test_done, test_pass, test_fail}, 3'b110);

    // R8 restart while busy ignored
    pulse_start();
    n = 0;
    repeat (20) begin @(posedge clk); n++; end
    start <= 1'b1;
    @(posedge clk); n++; start <= 1'b0;
    @(negedge clk);
    wait_done(n);
    chk(n == 161, "R8 run unaffected by second start", n, 161);
    chk(test_pass, "R8 still passes", test_pass, 1);

    // R6 data bit stuck low: pass 0 read of address 0
    fault = 1;
    pulse_start();
    n = 0;
    wait_done(n);
    chk(n == 18, "R4 stuck-bit fail timing", n, 18);
    chk(test_fail && !test_pass && fail_addr == 0, "R6 stuck-bit verdict",
        {test_fail, test_pass, fail_addr}, {1'b1, 1'b0, 4'h0});
    repeat (5) @(negedge clk);
    chk(!mem_we && mem_addr == 0, "R6 no access after fail", {mem_we, mem_addr}, 0);
    chk(test_fail && fail_addr == 0, "R7 fail held", {test_fail, fail_addr}, {1'b1, 4'h0});

    // R6 single cell bit0 stuck high: caught by 1010 pass at address 5
    fault = 3;
    pulse_start();
    n = 0;
    wait_done(n);
    chk(n == 55, "R4 cell-fault fail timing", n, 55);
    chk(test_fail && fail_addr == 5, "R6 cell-fault address", {test_fail, fail_addr}, {1'b1, 4'h5});

    // R3 address alias only caught in the address pass
    fault = 2;
    pulse_start();
    n = 0;
    wait_done(n);
    chk(n == 146, "R3 alias caught in address pass", n, 146);
    chk(test_fail && fail_addr == 0, "R3 alias fail address", {test_fail, fail_addr}, {1'b1, 4'h0});
    chk(!(test_pass && test_fail), "R9 exclusive on fail", {test_pass, test_fail}, 2'b01);

    // R1 reset mid-run
    fault = 0;
    pulse_start();
    repeat (40) @(posedge clk);
    rst <= 1'b1;
    @(posedge clk); rst <= 1'b0;
    @(negedge clk);
    chk({test_done, test_pass, test_fail, mem_we} == 0 && mem_addr == 0 && mem_wdata == 0,
        "R1 reset mid-run", {test_done, test_pass, test_fail, mem_we, mem_addr, mem_wdata}, 0);
    repeat (5) @(negedge clk);
    chk(!mem_we && !test_done, "R1 idle after reset", {mem_we, test_done}, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule